// File: doc/BRIEF.md
# Clock Group Stop and Power-Down Sequencer

This block turns eight groups of system clocks on and off without glitches. It derives every group from one root clock and answers three active-low asynchronous control pins. The first stops the processor-side groups. The second stops the bus group while leaving its free-running copy alive. The third powers the whole clock tree down. Each pin passes through a two-flop synchroniser. The result is then acted on at a rising edge of the free-running bus clock, so entry and exit latency is measured in bus-clock edges.

A gated output only starts a high phase when its group is enabled. It always finishes a high phase it has started, so it parks LOW and never emits a shortened pulse. Power-down takes precedence over both stop pins. It parks every group, including the always-on groups. One bus-clock period later it drops the oscillator/PLL enable. When power-down is released, the oscillator/PLL enable comes back at once. The groups stay parked until a stabilisation timer of `STAB_TICKS` bus-clock periods has expired. The timer length is a parameter, so a bench can shorten it.

Top module: `clkgate_pm`

## Requirements
- R1: While the CPU stop pin is LOW (after synchronisation), enable bits 0 (CPU group) and 1 (66 MHz-class group) are 0. Those outputs stay LOW. Enable bits 4 to 7 stay 1 and the memory-reference, IOAPIC, REF and 48 MHz outputs keep toggling.
- R2: While the PCI stop pin is LOW, enable bit 2 (PCI1..7) is 0 and those outputs stay LOW. Enable bit 3 (free-running PCI) stays 1 and that output keeps toggling.
- R3: A synchronised change of a stop pin takes effect at the next rising edge of the free-running PCI output. The enable bits change at that edge, and any PCI1..7 rise at that edge already follows the new state. With the pin driven just after a PCI rise, this is exactly 2*PCI_HALF root cycles later.
- R4: Every high pulse on a gated output lasts exactly its group's HALF parameter in root cycles; outputs stop and start only at low phases.
- R5: Power-down LOW clears all eight enable bits at the next free-running PCI edge, whose own rise is already suppressed. The oscillator/PLL enable drops one PCI period (2*PCI_HALF root cycles) later. All outputs then stay LOW whatever the stop pins do.
- R6: After power-down goes HIGH, the oscillator/PLL enable rises at the next PCI-rate tick and the stabilisation flag is 1. The first free-running PCI rise comes exactly STAB_TICKS*2*PCI_HALF root cycles after that. The enables then follow the stop pins as they are at that moment.
- R7: During and just after reset every output and every enable bit is 0, the oscillator/PLL enable is 1 and the stabilisation flag is 1. When the stabilisation period ends, all eight enable bits become 1.
- R8: Enable bit map: 0 CPU, 1 66 MHz-class, 2 PCI1..7, 3 free-running PCI, 4 memory reference, 5 IOAPIC, 6 REF, 7 48 MHz. All copies within a group are identical. Group periods are 2*HALF root cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_root | input | 1 | Root clock from which all groups are divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous CPU/66 MHz group stop request, active LOW |
| pci_stop_n | input | 1 | Asynchronous PCI1..7 stop request, active LOW |
| pwrdn_n | input | 1 | Asynchronous power-down request, active LOW |
| cpu_clk_o | output | CPU_N | CPU group clocks |
| c66_clk_o | output | C66_N | 66 MHz-class clocks |
| pci_clk_o | output | PCI_N | Stoppable PCI clocks |
| pcif_clk_o | output | 1 | Free-running PCI clock |
| mref_clk_o | output | MREF_N | Memory reference clocks (half CPU rate) |
| ioa_clk_o | output | IOA_N | IOAPIC clocks |
| ref_clk_o | output | REF_N | Reference clocks |
| usb_clk_o | output | 1 | 48 MHz clock |
| grp_en_o | output | 8 | Registered per-group enables, bit map in R8 |
| osc_pll_en_o | output | 1 | Oscillator and PLL enable |
| stab_wait_o | output | 1 | High while the stabilisation timer runs |

## Verification
The bound checker watches several properties on every cycle. Stopped CPU and PCI outputs stay parked. The enable bits only move at a PCI-rate tick. Every high pulse has its exact group width. All outputs are quiet while the oscillator is off, and nothing is enabled during stabilisation. The exact latency in PCI edges from a pin change, the precise stabilisation length, and the continued toggling of the unaffected groups are shown only by the bench's directed scenarios. So are the don't-care treatment of stop pins during power-down and the stop pins being applied at wake.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int NUM_GRP = 8;
  localparam int G_CPU  = 0;
  localparam int G_C66  = 1;
  localparam int G_PCI  = 2;
  localparam int G_PCIF = 3;
  localparam int G_MREF = 4;
  localparam int G_IOA  = 5;
  localparam int G_REF  = 6;
  localparam int G_USB  = 7;

  typedef enum logic [1:0] {
    PM_WAIT = 2'd0,
    PM_RUN  = 2'd1,
    PM_PARK = 2'd2,
    PM_OFF  = 2'd3
  } pm_state_e;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        hold_q <= 1'b1;
      end else begin
        meta_q <= async_i[i];
        hold_q <= meta_q;
      end
    end
    assign sync_o[i] = hold_q;
  end
endmodule

// File: rtl/gclk_div.sv
module gclk_div #(
  parameter int HALF   = 4,
  parameter int COPIES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_nx,
  output logic              rise_o,
  output logic [COPIES-1:0] clk_o
);
  localparam int CW = (HALF < 1) ? 1 : $clog2(2 * HALF);
  localparam logic [CW-1:0] LAST    = CW'(2 * HALF - 1);
  localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic          rise, fall;

  always_comb begin
    rise  = (cnt_q == RISE_AT);
    fall  = (cnt_q == LAST);
    cnt_d = fall ? '0 : cnt_q + CW'(1);
    out_d = out_q;
    // A high phase begins only if enabled; a started one always completes.
    if (rise)      out_d = en_nx;
    else if (fall) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign rise_o = rise;
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    assign clk_o[c] = out_q;
  end
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import pm_pkg::*;
#(
  parameter int STAB_TICKS = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               cstop_s,
  input  logic               pstop_s,
  input  logic               pdn_s,
  output logic [NUM_GRP-1:0] en_nx,
  output logic [NUM_GRP-1:0] grp_en,
  output logic               osc_pll_en,
  output logic               stab_wait
);
  localparam int SCW = $clog2(STAB_TICKS + 1);
  localparam logic [SCW-1:0] LOAD = SCW'(STAB_TICKS - 1);

  pm_state_e          state_q, state_d;
  logic [SCW-1:0]     scnt_q, scnt_d;
  logic [NUM_GRP-1:0] en_q, en_d, run_en;

  always_comb begin
    state_d = state_q;
    scnt_d  = scnt_q;
    if (tick) begin
      unique case (state_q)
        PM_WAIT: begin
          if (!pdn_s)               state_d = PM_PARK;
          else if (scnt_q == '0)    state_d = PM_RUN;
          else                      scnt_d  = scnt_q - SCW'(1);
        end
        PM_RUN:  if (!pdn_s) state_d = PM_PARK;
        PM_PARK: state_d = PM_OFF;
        default: begin
          if (pdn_s) begin
            state_d = PM_WAIT;
            scnt_d  = LOAD;
          end
        end
      endcase
    end
  end

  always_comb begin
    run_en         = '1;
    run_en[G_CPU]  = cstop_s;
    run_en[G_C66]  = cstop_s;
    run_en[G_PCI]  = pstop_s;
    if (tick) en_d = (state_d == PM_RUN) ? run_en : '0;
    else      en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_WAIT;
      scnt_q  <= LOAD;
      en_q    <= '0;
    end else begin
      state_q <= state_d;
      scnt_q  <= scnt_d;
      en_q    <= en_d;
    end
  end

  assign en_nx      = en_d;
  assign grp_en     = en_q;
  assign osc_pll_en = (state_q != PM_OFF);
  assign stab_wait  = (state_q == PM_WAIT);
endmodule

// File: rtl/clkgate_pm.sv
module clkgate_pm
  import pm_pkg::*;
#(
  parameter int CPU_N      = 4,
  parameter int C66_N      = 4,
  parameter int PCI_N      = 7,
  parameter int MREF_N     = 2,
  parameter int IOA_N      = 3,
  parameter int REF_N      = 2,
  parameter int CPU_HALF   = 1,
  parameter int C66_HALF   = 2,
  parameter int PCI_HALF   = 4,
  parameter int MREF_HALF  = 2,
  parameter int IOA_HALF   = 8,
  parameter int REF_HALF   = 5,
  parameter int USB_HALF   = 3,
  parameter int STAB_TICKS = 100000
) (
  input  logic               clk_root,
  input  logic               rst_n,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic               pwrdn_n,
  output logic [CPU_N-1:0]   cpu_clk_o,
  output logic [C66_N-1:0]   c66_clk_o,
  output logic [PCI_N-1:0]   pci_clk_o,
  output logic               pcif_clk_o,
  output logic [MREF_N-1:0]  mref_clk_o,
  output logic [IOA_N-1:0]   ioa_clk_o,
  output logic [REF_N-1:0]   ref_clk_o,
  output logic               usb_clk_o,
  output logic [NUM_GRP-1:0] grp_en_o,
  output logic               osc_pll_en_o,
  output logic               stab_wait_o
);
  // Every group high phase must fit inside one PCI period so that
  // power-down has parked all outputs before the oscillator is dropped.

  logic       rst_m_q, rst_s_q;
  logic [2:0] req_s;
  logic       pci_tick;
  logic [NUM_GRP-1:0] en_nx;
  logic [6:0] rise_unused;

  always_ff @(posedge clk_root or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  req_sync #(.W(3)) u_sync (
    .clk     (clk_root),
    .rst_n   (rst_s_q),
    .async_i ({pwrdn_n, pci_stop_n, cpu_stop_n}),
    .sync_o  (req_s)
  );

  pm_fsm #(.STAB_TICKS(STAB_TICKS)) u_fsm (
    .clk        (clk_root),
    .rst_n      (rst_s_q),
    .tick       (pci_tick),
    .cstop_s    (req_s[0]),
    .pstop_s    (req_s[1]),
    .pdn_s      (req_s[2]),
    .en_nx      (en_nx),
    .grp_en     (grp_en_o),
    .osc_pll_en (osc_pll_en_o),
    .stab_wait  (stab_wait_o)
  );

  gclk_div #(.HALF(PCI_HALF), .COPIES(1)) u_pcif (
    .clk(clk_root), .rst_n(rst_s_q), .en_nx(en_nx[G_PCIF]),
    .rise_o(pci_tick), .clk_o(pcif_clk_o));

  gclk_div #(.HALF(CPU_HALF), .COPIES(CPU_N)) u_cpu (
    .clk(clk_root), .rst_n(rst_s_q), .en_nx(en_nx[G_CPU]),
    .rise_o(rise_unused[0]), .clk_o(cpu_clk_o));

  gclk_div #(.HALF(C66_HALF), .COPIES(C66_N)) u_c66 (
    .clk(clk_root), .rst_n(rst_s_q), .en_nx(en_nx[G_C66]),
    .rise_o(rise_unused[1]), .clk_o(c66_clk_o));

  gclk_div #(.HALF(PCI_HALF), .COPIES(PCI_N)) u_pci (
    .clk(clk_root), .rst_n(rst_s_q), .en_nx(en_nx[G_PCI]),
    .rise_o(rise_unused[2]), .clk_o(pci_clk_o));

  gclk_div #(.HALF(MREF_HALF), .COPIES(MREF_N)) u_mref (
    .clk(clk_root), .rst_n(rst_s_q), .en_nx(en_nx[G_MREF]),
    .rise_o(rise_unused[3]), .clk_o(mref_clk_o));

  gclk_div #(.HALF(IOA_HALF), .COPIES(IOA_N)) u_ioa (
    .clk(clk_root), .rst_n(rst_s_q), .en_nx(en_nx[G_IOA]),
    .rise_o(rise_unused[4]), .clk_o(ioa_clk_o));

  gclk_div #(.HALF(REF_HALF), .COPIES(REF_N)) u_ref (
    .clk(clk_root), .rst_n(rst_s_q), .en_nx(en_nx[G_REF]),
    .rise_o(rise_unused[5]), .clk_o(ref_clk_o));

  gclk_div #(.HALF(USB_HALF), .COPIES(1)) u_usb (
    .clk(clk_root), .rst_n(rst_s_q), .en_nx(en_nx[G_USB]),
    .rise_o(rise_unused[6]), .clk_o(usb_clk_o));
endmodule

// File: rtl/clkgate_pm_chk.sv
module clkgate_pm_chk #(
  parameter int CPU_HALF = 1,
  parameter int PCI_HALF = 4,
  parameter int IOA_HALF = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pci_tick,
  input logic       cpu0,
  input logic       c660,
  input logic       pci0,
  input logic       pcif,
  input logic       mref0,
  input logic       ioa0,
  input logic       ref0,
  input logic       usb,
  input logic [7:0] grp_en,
  input logic       osc_en,
  input logic       stab_wait
);
  logic [7:0] hi_cpu, hi_pcif, hi_ioa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cpu  <= '0;
      hi_pcif <= '0;
      hi_ioa  <= '0;
    end else begin
      hi_cpu  <= cpu0 ? hi_cpu + 8'd1 : 8'd0;
      hi_pcif <= pcif ? hi_pcif + 8'd1 : 8'd0;
      hi_ioa  <= ioa0 ? hi_ioa + 8'd1 : 8'd0;
    end
  end

  p_cpu_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_en[0] && !cpu0) |=> (!cpu0 || grp_en[0]));

  p_free_groups_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grp_en[0] |-> (&grp_en[7:3]));

  p_pci_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_en[2] && !pci0) |=> (!pci0 || grp_en[2]));

  p_en_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grp_en) |-> $past(pci_tick));

  p_cpu_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu0) |-> (hi_cpu == 8'(CPU_HALF)));

  p_pcif_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pcif) |-> (hi_pcif == 8'(PCI_HALF)));

  p_ioa_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ioa0) |-> (hi_ioa == 8'(IOA_HALF)));

  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !(cpu0 | c660 | pci0 | pcif | mref0 | ioa0 | ref0 | usb));

  p_wait_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stab_wait |-> (grp_en == 8'h00));
endmodule

bind clkgate_pm clkgate_pm_chk #(
  .CPU_HALF(CPU_HALF), .PCI_HALF(PCI_HALF), .IOA_HALF(IOA_HALF)
) u_chk (
  .clk       (clk_root),
  .rst_n     (rst_n),
  .pci_tick  (pci_tick),
  .cpu0      (cpu_clk_o[0]),
  .c660      (c66_clk_o[0]),
  .pci0      (pci_clk_o[0]),
  .pcif      (pcif_clk_o),
  .mref0     (mref_clk_o[0]),
  .ioa0      (ioa_clk_o[0]),
  .ref0      (ref_clk_o[0]),
  .usb       (usb_clk_o),
  .grp_en    (grp_en_o),
  .osc_en    (osc_pll_en_o),
  .stab_wait (stab_wait_o)
);

// File: tb/sim_clkgate_pm.sv
`timescale 1ns/1ps
module sim_clkgate_pm;
  localparam int STAB = 4;
  localparam int PH   = 4;
  localparam int TICK = 2 * PH;
  localparam int WIN  = 64;

  logic clk = 1'b0;
  logic rst_n, cpu_stop_n, pci_stop_n, pwrdn_n;
  logic [3:0] cpu_clk_o, c66_clk_o;
  logic [6:0] pci_clk_o;
  logic pcif_clk_o, usb_clk_o, osc_pll_en_o, stab_wait_o;
  logic [1:0] mref_clk_o, ref_clk_o;
  logic [2:0] ioa_clk_o;
  logic [7:0] grp_en_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit mon_on = 0;
  int bad_pulse = 0;
  logic p_pcif, p_cpu, p_c66, p_pci, p_mref, p_ioa, p_ref, p_usb;

  always #4 clk = ~clk;

  clkgate_pm #(.STAB_TICKS(STAB)) u0 (
    .clk_root(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n), .cpu_clk_o(cpu_clk_o),
    .c66_clk_o(c66_clk_o), .pci_clk_o(pci_clk_o), .pcif_clk_o(pcif_clk_o),
    .mref_clk_o(mref_clk_o), .ioa_clk_o(ioa_clk_o), .ref_clk_o(ref_clk_o),
    .usb_clk_o(usb_clk_o), .grp_en_o(grp_en_o), .osc_pll_en_o(osc_pll_en_o),
    .stab_wait_o(stab_wait_o));

  // {cpu_stop_n, pci_stop_n, expected grp_en}
  localparam logic [9:0] VEC [4] = '{
    {1'b1, 1'b1, 8'hFF},
    {1'b0, 1'b1, 8'hFC},
    {1'b1, 1'b0, 8'hFB},
    {1'b0, 1'b0, 8'hF8}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    p_pcif = pcif_clk_o; p_cpu = cpu_clk_o[0]; p_c66 = c66_clk_o[0];
    p_pci = pci_clk_o[0]; p_mref = mref_clk_o[0]; p_ioa = ioa_clk_o[0];
    p_ref = ref_clk_o[0]; p_usb = usb_clk_o;
    @(negedge clk);
  endtask

  task automatic wait_pcif_rise();
    for (int i = 0; i < 400; i++) begin
      step();
      if (pcif_clk_o && !p_pcif) return;
    end
    chk("R3 free PCI rise timeout", 0, 1);
  endtask

  // Counts rises on copy 0 of each group over WIN cycles; checks copy agreement.
  task automatic window(input logic [7:0] en, input string tag);
    int c_cpu = 0, c_c66 = 0, c_pci = 0, c_pcif = 0;
    int c_mref = 0, c_ioa = 0, c_ref = 0, c_usb = 0, bad_copy = 0;
    for (int i = 0; i < WIN; i++) begin
      step();
      c_cpu  += (cpu_clk_o[0] && !p_cpu);
      c_c66  += (c66_clk_o[0] && !p_c66);
      c_pci  += (pci_clk_o[0] && !p_pci);
      c_pcif += (pcif_clk_o && !p_pcif);
      c_mref += (mref_clk_o[0] && !p_mref);
      c_ioa  += (ioa_clk_o[0] && !p_ioa);
      c_ref  += (ref_clk_o[0] && !p_ref);
      c_usb  += (usb_clk_o && !p_usb);
      if (cpu_clk_o != {4{cpu_clk_o[0]}} || c66_clk_o != {4{c66_clk_o[0]}} ||
          pci_clk_o != {7{pci_clk_o[0]}} || ioa_clk_o != {3{ioa_clk_o[0]}} ||
          mref_clk_o != {2{mref_clk_o[0]}} || ref_clk_o != {2{ref_clk_o[0]}})
        bad_copy++;
    end
    chk({tag, " R1 cpu rises"},  c_cpu,  en[0] ? WIN/2  : 0);
    chk({tag, " R1 66 rises"},   c_c66,  en[1] ? WIN/4  : 0);
    chk({tag, " R2 pci rises"},  c_pci,  en[2] ? WIN/8  : 0);
    chk({tag, " R2 pcif rises"}, c_pcif, en[3] ? WIN/8  : 0);
    chk({tag, " R1 mref rises"}, c_mref, en[4] ? WIN/4  : 0);
    chk({tag, " R1 ioa rises"},  c_ioa,  en[5] ? WIN/16 : 0);
    chk({tag, " R1 ref toggles"}, (c_ref != 0), en[6]);
    chk({tag, " R1 usb toggles"}, (c_usb != 0), en[7]);
    chk({tag, " R8 copies equal"}, bad_copy, 0);
  endtask

  // Pulse-width monitor for R4 (high runs of CPU, PCI and IOAPIC copy 0).
  initial begin
    int l_cpu = 0, l_pci = 0, l_ioa = 0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (cpu_clk_o[0]) l_cpu++; else begin if (l_cpu != 0 && l_cpu != 1) bad_pulse++; l_cpu = 0; end
        if (pci_clk_o[0]) l_pci++; else begin if (l_pci != 0 && l_pci != 4) bad_pulse++; l_pci = 0; end
        if (ioa_clk_o[0]) l_ioa++; else begin if (l_ioa != 0 && l_ioa != 8) bad_pulse++; l_ioa = 0; end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwrdn_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 reset outputs", {cpu_clk_o, pci_clk_o, pcif_clk_o, usb_clk_o}, 0);
    chk("R7 reset enables", grp_en_o, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R7 after release enables", grp_en_o, 8'h00);
    chk("R7 after release osc", osc_pll_en_o, 1);
    chk("R7 after release stab", stab_wait_o, 1);
    mon_on = 1;
    for (int i = 0; i < 200 && stab_wait_o; i++) step();
    chk("R7 stabilised enables", grp_en_o, 8'hFF);

    // Table walk: stop pin combinations
    foreach (VEC[v]) begin
      wait_pcif_rise();
      cpu_stop_n = VEC[v][9];
      pci_stop_n = VEC[v][8];
      repeat (3) wait_pcif_rise();
      chk("R8 enable map", grp_en_o, VEC[v][7:0]);
      window(VEC[v][7:0], "vec");
    end
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    repeat (3) wait_pcif_rise();

    // R3: CPU stop latency
    wait_pcif_rise();
    cpu_stop_n = 1'b0;
    repeat (TICK - 1) step();
    chk("R3 cpu enable before edge", grp_en_o[0], 1);
    step();
    chk("R3 free PCI edge reached", pcif_clk_o && !p_pcif, 1);
    chk("R3 cpu enable at edge", grp_en_o[0], 0);
    window(8'hFC, "R1 stopped");
    wait_pcif_rise();
    cpu_stop_n = 1'b1;
    wait_pcif_rise();
    chk("R3 cpu enable restart", grp_en_o[0], 1);
    step();
    chk("R3 cpu first rise", cpu_clk_o, 4'hF);

    // R3: PCI stop and start latency
    wait_pcif_rise();
    pci_stop_n = 1'b0;
    wait_pcif_rise();
    chk("R3 pci suppressed at edge", pci_clk_o, 7'h00);
    chk("R2 pcif runs at edge", pcif_clk_o, 1);
    wait_pcif_rise();
    pci_stop_n = 1'b1;
    wait_pcif_rise();
    chk("R3 pci restored at edge", pci_clk_o, 7'h7F);

    // R5: power-down entry
    wait_pcif_rise();
    pwrdn_n = 1'b0;
    repeat (TICK) step();
    chk("R5 enables cleared", grp_en_o, 8'h00);
    chk("R5 pcif rise suppressed", pcif_clk_o, 0);
    chk("R5 osc still on", osc_pll_en_o, 1);
    repeat (TICK - 1) step();
    chk("R5 osc before drop", osc_pll_en_o, 1);
    step();
    chk("R5 osc dropped", osc_pll_en_o, 0);
    cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
    window(8'h00, "R5 pd");
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    window(8'h00, "R5 pd dontcare");
    chk("R5 enables stay clear", grp_en_o, 8'h00);

    // R6: wake with CPU stop held low
    cpu_stop_n = 1'b0;
    pwrdn_n = 1'b1;
    for (int i = 0; i < 40 && !osc_pll_en_o; i++) step();
    chk("R6 osc back", osc_pll_en_o, 1);
    chk("R6 stabilising", stab_wait_o, 1);
    n = 0;
    for (int i = 0; i < 400 && !pcif_clk_o; i++) begin step(); n++; end
    chk("R6 stabilisation cycles", n, STAB * TICK);
    chk("R6 stab done", stab_wait_o, 0);
    chk("R6 stop applied at wake", grp_en_o, 8'hFC);
    window(8'hFC, "R6 wake");
    cpu_stop_n = 1'b1;
    repeat (3) wait_pcif_rise();
    chk("R6 all running", grp_en_o, 8'hFF);

    chk("R4 pulse widths", bad_pulse, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule